// File: doc/BRIEF.md
# Slope-Aware Redundant Current-DAC Code Encoder

This block sits between an offset-calibration loop and a current-steering trim DAC that carries one extra weight-8 cell. The loop delivers a 7-bit binary correction code with a valid strobe. The encoder turns each code into an 8-bit DAC control word whose ideal cell weights are 1, 2, 4, 8, 8, 16, 32 and 64, so the ideal output total always equals the input code.

The code range is split into 16 intervals of eight codes each. The encoder watches which way the interval index last moved. When the code is climbing and lands in the upper half of a 16-code region (weight-16 set, weight-8 clear), it drives both weight-8 cells in place of the weight-16 cell. When the code is falling, it uses the plain binary mapping. The real DAC cells carry mismatch. Approaching a region from below and from above then passes through different physical cells, so a weight-16 cell that is off by less than 8 LSB leaves no code unreachable while the loop settles.

Each accepted code yields one registered control word one clock later.

Top module: `slope_redundant_encoder`

## Requirements
- R1: While reset is asserted, out_valid is 0 and out_word is all zeros.
- R2: out_valid is high in exactly the cycles that follow a cycle with in_valid high, giving one clock of latency.
- R3: For every accepted code and in both slope states, the ideal weight sum of out_word equals the input code. The weights by bit, from bit 0 to bit 7, are 1, 2, 4, 8, 8, 16, 32 and 64.
- R4: The out_word bit layout is as follows. Bits 2..0 copy code bits 2..0. Bit 3 is the primary weight-8 cell and bit 4 the redundant weight-8 cell. Bit 5 is the weight-16 cell. Bits 6 and 7 copy code bits 5 and 6. Outside the substitution case of R5, bit 3 equals code bit 3 and bit 5 equals code bit 4.
- R5: When the slope is rising and code bits 4..3 are 2'b10, out_word bits 5..3 are 3'b011: both weight-8 cells on, weight-16 cell off.
- R6: When the slope is falling, bit 4 (the redundant cell) is 0 and the mapping is plain binary.
- R7: The interval index is the code shifted right by 3. An accepted code whose index is higher than the previous accepted index makes the slope rising. A lower index makes it falling. An equal index keeps the slope. The updated slope already governs the encoding of the code that caused the change.
- R8: After reset the slope is rising. The first accepted code after reset only records its index and does not change the slope.
- R9: While in_valid is low, out_word holds its value. A code presented without a strobe does not alter the recorded index or the slope.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe marking in_code as a new correction code |
| in_code | input | 7 | Binary offset-correction code |
| out_valid | output | 1 | Strobe marking out_word as freshly encoded |
| out_word | output | 8 | Redundant DAC control word, layout per R4 |

## Verification
Every result is due one clock after its stimulus: the control word and its strobe appear at the first rising edge after the code is offered. The slope decision has no extra delay, because it is resolved combinationally from the code that arrives with that strobe. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each sample lands one full edge after the register that produced it. A reference model in the bench updates its index and slope only for strobed codes. It runs full rising and falling ramps, so every code is encoded in both slope states, and it also covers idle gaps and a mid-run reset.

// File: rtl/sre_pkg.sv
package sre_pkg;

  typedef enum logic {
    SLOPE_FALL = 1'b0,
    SLOPE_RISE = 1'b1
  } slope_e;

  // Ideal weight of output cell position 'pos' for a grouping shift of 'g'.
  function automatic int unsigned cell_weight(input int unsigned pos, input int unsigned g);
    int unsigned w;
    if (pos < g)          w = 1 << pos;
    else if (pos <= g + 1) w = 1 << g;
    else                  w = 1 << (pos - 1);
    return w;
  endfunction

endpackage

// File: rtl/sre_slope_tracker.sv
module sre_slope_tracker #(
  parameter int CODE_W = 7,
  parameter int GRP_SH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  output sre_pkg::slope_e   slope_now
);
  import sre_pkg::*;

  localparam int IDX_W = CODE_W - GRP_SH;

  logic [IDX_W-1:0] idx_cur;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             armed_q, armed_d;
  slope_e           slope_q, slope_d;

  assign idx_cur = code[CODE_W-1:GRP_SH];

  always_comb begin
    slope_d = slope_q;
    idx_d   = idx_q;
    armed_d = armed_q;
    if (take) begin
      if (armed_q && (idx_cur > idx_q)) slope_d = SLOPE_RISE;
      else if (armed_q && (idx_cur < idx_q)) slope_d = SLOPE_FALL;
      idx_d   = idx_cur;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slope_q <= SLOPE_RISE;
      idx_q   <= '0;
      armed_q <= 1'b0;
    end else if (take) begin
      slope_q <= slope_d;
      idx_q   <= idx_d;
      armed_q <= armed_d;
    end
  end

  assign slope_now = slope_d;

endmodule

// File: rtl/sre_cell_mapper.sv
module sre_cell_mapper #(
  parameter int CODE_W = 7,
  parameter int GRP_SH = 3
) (
  input  logic [CODE_W-1:0] code,
  input  sre_pkg::slope_e   slope,
  output logic [CODE_W:0]   cells
);
  import sre_pkg::*;

  logic swap;

  assign swap = (slope == SLOPE_RISE) && code[GRP_SH+1] && !code[GRP_SH];

  generate
    for (genvar i = 0; i < GRP_SH; i++) begin : g_low
      assign cells[i] = code[i];
    end
    for (genvar k = GRP_SH + 2; k < CODE_W; k++) begin : g_high
      assign cells[k+1] = code[k];
    end
  endgenerate

  assign cells[GRP_SH]     = code[GRP_SH] | swap;
  assign cells[GRP_SH + 1] = swap;
  assign cells[GRP_SH + 2] = code[GRP_SH+1] & ~swap;

endmodule

// File: rtl/sre_out_stage.sv
module sre_out_stage #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] word_in,
  output logic             valid_q,
  output logic [OUT_W-1:0] word_q
);
  logic [OUT_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (load) word_d = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= load;
      word_q  <= word_d;
    end
  end

endmodule

// File: rtl/slope_redundant_encoder.sv
module slope_redundant_encoder #(
  parameter int CODE_W = 7,
  parameter int GRP_SH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [CODE_W:0]   out_word
);
  import sre_pkg::*;

  localparam int OUT_W = CODE_W + 1;

  slope_e           slope_now;
  logic [OUT_W-1:0] cells;

  sre_slope_tracker #(.CODE_W(CODE_W), .GRP_SH(GRP_SH)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (in_valid),
    .code      (in_code),
    .slope_now (slope_now)
  );

  sre_cell_mapper #(.CODE_W(CODE_W), .GRP_SH(GRP_SH)) u_map (
    .code  (in_code),
    .slope (slope_now),
    .cells (cells)
  );

  sre_out_stage #(.OUT_W(OUT_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .word_in (cells),
    .valid_q (out_valid),
    .word_q  (out_word)
  );

endmodule

// File: rtl/sre_checker.sv
module sre_checker #(
  parameter int CODE_W = 7,
  parameter int GRP_SH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic [CODE_W:0]   out_word
);
  import sre_pkg::*;

  function automatic int unsigned word_sum(input logic [CODE_W:0] w);
    int unsigned s;
    s = 0;
    for (int i = 0; i <= CODE_W; i++) if (w[i]) s += cell_weight(i, GRP_SH);
    return s;
  endfunction

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (word_sum(out_word) == int'(unsigned'($past(in_code)))));

  // R4
  low_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_word[GRP_SH-1:0] == $past(in_code[GRP_SH-1:0])));

  // R5
  swap_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_word[GRP_SH+1] |-> (out_word[GRP_SH] && !out_word[GRP_SH+2]));

  // R9
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));

endmodule

bind slope_redundant_encoder sre_checker #(.CODE_W(CODE_W), .GRP_SH(GRP_SH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_code   (in_code),
  .out_valid (out_valid),
  .out_word  (out_word)
);

// File: tb/slope_redundant_encoder_bench.sv
module slope_redundant_encoder_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [6:0] in_code;
  logic       out_valid;
  logic [7:0] out_word;

  int checks = 0;
  int errors = 0;
  bit m_rise;
  bit m_armed;
  int m_last;
  logic [7:0] m_word;

  always #5 clk = ~clk;

  slope_redundant_encoder u_slope_redundant_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [7:0] exp_word(input int code, input bit rise);
    logic [6:0] c;
    logic [7:0] w;
    c = code[6:0];
    w = {c[6], c[5], c[4], 1'b0, c[3], c[2:0]};
    if (rise && c[4] && !c[3]) begin
      w[5] = 1'b0; w[4] = 1'b1; w[3] = 1'b1;
    end
    return w;
  endfunction

  function automatic int wsum(input logic [7:0] w);
    int wt[8] = '{1, 2, 4, 8, 8, 16, 32, 64};
    int s = 0;
    for (int i = 0; i < 8; i++) if (w[i]) s += wt[i];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rise = 1'b1; m_armed = 1'b0; m_last = 0; m_word = '0;
  endtask

  // Drive at falling edge, sample one clock later at the next falling edge.
  task automatic send(input bit v, input int code, input string tag);
    logic [7:0] exp;
    int idx;
    in_valid = v;
    in_code  = code[6:0];
    if (v) begin
      idx = code >> 3;
      if (m_armed && idx > m_last) m_rise = 1'b1;
      else if (m_armed && idx < m_last) m_rise = 1'b0;
      m_last = idx; m_armed = 1'b1;
      m_word = exp_word(code, m_rise);
    end
    exp = m_word;
    @(negedge clk);
    check(out_valid == v, "R2", out_valid, v);
    if (v) begin
      if (tag.len() != 0) check(out_word == exp, tag, out_word, exp);
      else if (code[4:3] == 2'b10) check(out_word == exp, m_rise ? "R5" : "R6", out_word, exp);
      else check(out_word == exp, "R4", out_word, exp);
      check(wsum(out_word) == code, "R3", wsum(out_word), code);
    end else begin
      check(out_word == exp, "R9", out_word, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_code = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(out_word == 8'h00, "R1", out_word, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R8: first sample after reset is encoded with rising slope
    send(1, 16, "R8");
    check(out_word == 8'b0001_1000, "R8", out_word, 8'b0001_1000);
    // R7: index 2 -> 1 gives falling, 1 -> 2 rising on the same sample
    send(1, 8, "R7");
    send(1, 18, "R7");
    check(out_word[4] == 1'b1, "R7", out_word[4], 1);
    send(1, 40, "R7");
    send(1, 20, "R7");
    check(out_word[4] == 1'b0 && out_word[5] == 1'b1, "R7", out_word, 8'b0010_0100);
    // R7: equal index holds the falling slope
    send(1, 17, "R7");
    check(out_word[4] == 1'b0, "R7", out_word[4], 0);
    // R9: unstrobed codes leave word, index and slope alone
    send(0, 120, "");
    send(0, 0, "");
    send(1, 22, "R9");
    check(out_word[4] == 1'b0, "R9", out_word[4], 0);
    // Full ramps in both directions
    for (int c = 0; c < 128; c++) send(1, c, "");
    for (int c = 127; c >= 0; c--) send(1, c, "");
    // Interleaved strobes
    for (int c = 0; c < 128; c += 3) begin
      send(1, c, "");
      send(0, 127 - c, "");
    end
    // R8: reset from a falling state returns to rising
    send(1, 100, "");
    send(1, 60, "");
    do_reset();
    send(1, 0, "R8");
    send(1, 16, "R8");
    check(out_word == 8'b0001_1000, "R8", out_word, 8'b0001_1000);
    in_valid = 1'b0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule